// File: doc/BRIEF.md
# Storage key protection checker

This block sits on the path from a processor's memory request port to the memory and enforces per-block storage protection. The address space is cut into blocks of 2,048 bytes. Each block owns a 4-bit key that lives in a private key array. Ordinary loads and stores can neither read nor change that array. On every load or store, the block looks up the key of the addressed block and compares it with the key held in the current status word. A request that matches goes to memory in the same cycle. A request that does not match is consumed, never reaches memory, and raises a protection interrupt.

The block also executes the privileged set-key command, which writes a new key for the addressed block. The command takes effect only while the status word says supervisor state. In problem state the command is refused and a privileged-operation interrupt is raised instead.

The request side is a valid/ready stream. Granted loads and stores pass to the memory-side stream with no added cycle, and back-pressure from memory shows up directly on `req_ready`. Refused requests and set-key commands need no memory and are always accepted at once. The status-word inputs and the interrupt outputs are plain signals.

Top module: `skp_guard`

## Requirements
- R1: After reset every block key is 0, so a load with status key 3 to any block is refused, while a load with status key 0 is granted.
- R2: The block index is the address bits above bit 10 (`req_addr[ADDR_W-1:11]`). All byte addresses inside one 2,048-byte block share a single key, and the first byte of the next block uses a different key.
- R3: A load (`req_op`=00) or store (`req_op`=01) is forwarded (`mem_valid`=1) exactly when `req_valid` is 1 and either the status key is 0 or it equals the addressed block's key.
- R4: A load or store whose key does not match is accepted (`req_ready`=1), does not assert `mem_valid`, and causes `irq_valid`=1 with `irq_cause`=01 on the cycle after it is accepted.
- R5: A set-key command (`req_op`=10 or 11) accepted while `psw_problem`=0 writes `req_newkey` as the key of the addressed block, is accepted immediately, never asserts `mem_valid`, and raises no interrupt.
- R6: A set-key command while `psw_problem`=1 leaves the block key unchanged and causes `irq_valid`=1 with `irq_cause`=10 on the next cycle.
- R7: Loads and stores never change any block key, whatever their address or data.
- R8: On a forwarded request, `mem_addr`, `mem_we` (= `req_op[0]`) and `mem_wdata` equal the request fields in the same cycle, and `req_ready` equals `mem_ready`. While `mem_ready`=0 the request is held.
- R9: `irq_valid` is a one-cycle pulse for each refused request. While `irq_valid`=0, `irq_cause` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psw_key | input | 4 | Key field of the current status word |
| psw_problem | input | 1 | Problem-state bit of the status word (1 = unprivileged) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 00 load, 01 store, 1x set-key |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_newkey | input | 4 | Key value for set-key |
| mem_valid | output | 1 | Forwarded request to memory |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Forwarded request is a store |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded store data |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_cause | output | 2 | 01 protection, 10 privileged operation, 00 none |

## Verification
On every cycle, the assertions check the following. A forwarded request always carries a key the status word may use. A request the block refused never had a memory request in the cycle before its interrupt. Ready follows memory on grants. The key array holds still unless a write is enabled, and each write lands where it was aimed. The interrupt cause is one-hot when valid and zero otherwise.

Some behaviour only the bench's scenarios can show. These cover the reset value of the keys, the block boundary at bit 11, and the survival of keys across refused set-key commands and across stores. They also cover the pairing of each refused request with the right cause one cycle later. The bench compares all of this against its own key table on every clock.

// File: rtl/skp_pkg.sv
package skp_pkg;
  localparam int KEY_W = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PROT = 2'b01,
    CAUSE_PRIV = 2'b10
  } skp_cause_e;
endpackage

// File: rtl/skp_key_store.sv
module skp_key_store #(
  parameter int NBLK  = 256,
  parameter int KEY_W = 4,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0] rd_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key
);
  logic [KEY_W-1:0]      key_q [NBLK];
  logic [NBLK*KEY_W-1:0] key_flat;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) key_q[g] <= wr_key;
    end
    assign key_flat[g*KEY_W +: KEY_W] = key_q[g];
  end

  assign rd_key = key_q[rd_idx];

  // R7: keys only move on an enabled write
  a_r7_keys_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(key_flat));
  // R5: an enabled write lands in the addressed block
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> key_q[$past(wr_idx)] == $past(wr_key));
endmodule

// File: rtl/skp_key_match.sv
module skp_key_match #(
  parameter int KEY_W    = 4,
  parameter bit ZERO_ALL = 1'b1
) (
  input  logic [KEY_W-1:0] blk_key,
  input  logic [KEY_W-1:0] psw_key,
  output logic             hit
);
  logic same;
  assign same = (blk_key == psw_key);

  if (ZERO_ALL) begin : g_master
    assign hit = same || (psw_key == '0);
  end else begin : g_strict
    assign hit = same;
  end
endmodule

// File: rtl/skp_irq_gen.sv
module skp_irq_gen
  import skp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raise_prot,
  input  logic       raise_priv,
  output logic       irq_valid,
  output logic [1:0] irq_cause
);
  skp_cause_e cause_d, cause_q;

  always_comb begin
    cause_d = CAUSE_NONE;
    if (raise_priv)      cause_d = CAUSE_PRIV;
    else if (raise_prot) cause_d = CAUSE_PROT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_NONE;
    else        cause_q <= cause_d;
  end

  assign irq_valid = (cause_q != CAUSE_NONE);
  assign irq_cause = cause_q;

  a_r9_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_cause == 2'b00);
  a_r9_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $onehot0(irq_cause) && irq_cause != 2'b00);
endmodule

// File: rtl/skp_guard.sv
module skp_guard
  import skp_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 32,
  parameter int BLK_LOG2 = 11,
  localparam int IDX_W   = ADDR_W - BLK_LOG2,
  localparam int NBLK    = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        psw_key,
  input  logic              psw_problem,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [3:0]        req_newkey,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq_valid,
  output logic [1:0]        irq_cause
);
  logic [IDX_W-1:0] blk_idx;
  logic [KEY_W-1:0] blk_key;
  logic             key_hit, is_setkey, is_access, access_ok;
  logic             key_we, raise_prot, raise_priv;

  assign blk_idx   = req_addr[ADDR_W-1:BLK_LOG2];
  assign is_setkey = req_op[1];
  assign is_access = !req_op[1];

  skp_key_store #(.NBLK(NBLK), .KEY_W(KEY_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(blk_idx), .rd_key(blk_key),
    .wr_en(key_we), .wr_idx(blk_idx), .wr_key(req_newkey)
  );

  skp_key_match #(.KEY_W(KEY_W), .ZERO_ALL(1'b1)) u_match (
    .blk_key(blk_key), .psw_key(psw_key), .hit(key_hit)
  );

  assign access_ok  = is_access && key_hit;
  assign mem_valid  = req_valid && access_ok;
  assign req_ready  = access_ok ? mem_ready : 1'b1;
  assign mem_we     = req_op[0];
  assign mem_addr   = req_addr;
  assign mem_wdata  = req_wdata;

  assign key_we     = req_valid && is_setkey && !psw_problem;
  assign raise_prot = req_valid && is_access && !key_hit;
  assign raise_priv = req_valid && is_setkey && psw_problem;

  skp_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n),
    .raise_prot(raise_prot), .raise_priv(raise_priv),
    .irq_valid(irq_valid), .irq_cause(irq_cause)
  );

  // R4: a refused request never reached memory
  a_r4_refused_not_sent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mem_valid));
  // R3: only keys the status word may use pass through
  a_r3_grant_key_ok: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (psw_key == 4'd0 || blk_key == psw_key));
  // R8: ready mirrors memory on a grant
  a_r8_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> req_ready == mem_ready);
endmodule

// File: tb/skp_guard_tb_top.sv
module skp_guard_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  psw_key = 0;
  logic        psw_problem = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [1:0]  req_op = 0;
  logic [18:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0]  req_newkey = 0;
  logic        mem_valid, mem_ready = 1, mem_we;
  logic [18:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        irq_valid;
  logic [1:0]  irq_cause;

  int checks = 0, failures = 0;
  int model_key [256];
  bit exp_irq = 0;
  int exp_cause = 0;
  bit done = 0;

  always #5 clk = ~clk;

  skp_guard dut_i (.*);

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock of stimulus; compares at the falling edge against the model
  task automatic step(string tag, bit v, logic [1:0] op, logic [18:0] a,
                      logic [3:0] sk, bit prob, logic [3:0] nk, bit mr,
                      logic [31:0] wd);
    int  idx;
    bit  acc, hit;
    req_valid = v; req_op = op; req_addr = a; psw_key = sk;
    psw_problem = prob; req_newkey = nk; mem_ready = mr; req_wdata = wd;
    @(negedge clk);
    idx = int'(a >> 11);
    acc = !op[1];
    hit = (sk == 0) || (model_key[idx] == int'(sk));
    chk(tag, "mem_valid", mem_valid, v && acc && hit);
    chk(tag, "req_ready", req_ready, (acc && hit) ? mr : 1'b1);
    chk(exp_cause == 2 ? "R6" : "R4", "irq_valid", irq_valid, exp_irq);
    chk("R9", "irq_cause", irq_cause, exp_cause);
    if (v && acc && hit) begin
      chk("R8", "mem_addr", mem_addr, a);
      chk("R8", "mem_we", mem_we, op[0]);
      chk("R8", "mem_wdata", mem_wdata, wd);
    end
    exp_irq = 0; exp_cause = 0;
    if (v && acc && !hit) begin exp_irq = 1; exp_cause = 1; end
    if (v && op[1] && prob) begin exp_irq = 1; exp_cause = 2; end
    if (v && op[1] && !prob) model_key[idx] = int'(nk);
    @(posedge clk); #1;
  endtask

  initial begin
    foreach (model_key[i]) model_key[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9: quiet interrupt after reset; R1: keys start at zero
    step("R9", 0, 2'b00, 19'h0, 4'd0, 0, 4'd0, 1, 32'h0);
    step("R1", 1, 2'b00, 19'h2800, 4'd0, 0, 4'd0, 1, 32'h0);
    step("R1", 1, 2'b00, 19'h2800, 4'd3, 1, 4'd0, 1, 32'h0);
    step("R4", 0, 2'b00, 19'h0, 4'd3, 1, 4'd0, 1, 32'h0);
    // R5: supervisor sets block 5 to key 3
    step("R5", 1, 2'b10, 19'h2900, 4'd0, 0, 4'd3, 1, 32'h0);
    step("R3", 1, 2'b00, 19'h2800, 4'd3, 1, 4'd0, 1, 32'h0);
    // R2: last byte of block 5 shares the key, next block does not
    step("R2", 1, 2'b01, 19'h2FFF, 4'd3, 1, 4'd0, 1, 32'hCAFE_0001);
    step("R2", 1, 2'b01, 19'h3000, 4'd3, 1, 4'd0, 1, 32'hCAFE_0002);
    // R6: problem-state set-key refused, key stays 3
    step("R6", 1, 2'b10, 19'h2800, 4'd3, 1, 4'd7, 1, 32'h0);
    step("R6", 1, 2'b00, 19'h2800, 4'd3, 1, 4'd0, 1, 32'h0);
    step("R6", 1, 2'b00, 19'h2800, 4'd7, 1, 4'd0, 1, 32'h0);
    // R7: stores with all-ones data leave keys alone
    step("R7", 1, 2'b01, 19'h2800, 4'd0, 0, 4'hF, 1, 32'hFFFF_FFFF);
    step("R7", 1, 2'b00, 19'h2804, 4'd3, 1, 4'd0, 1, 32'h0);
    // R8: back-pressure holds the request
    step("R8", 1, 2'b01, 19'h2810, 4'd3, 1, 4'd0, 0, 32'h1234_5678);
    step("R8", 1, 2'b01, 19'h2810, 4'd3, 1, 4'd0, 0, 32'h1234_5678);
    step("R8", 1, 2'b01, 19'h2810, 4'd3, 1, 4'd0, 1, 32'h1234_5678);
    // R5: op 11 also sets a key
    step("R5", 1, 2'b11, 19'h0, 4'd0, 0, 4'd2, 1, 32'h0);
    step("R5", 1, 2'b00, 19'h10, 4'd2, 1, 4'd0, 1, 32'h0);
    // mixed traffic over eight blocks
    for (int n = 0; n < 600; n++) begin
      logic [18:0] ra;
      ra = 19'({$urandom_range(0, 7), 11'($urandom)});
      step("R3", 1'($urandom_range(0, 3) != 0), 2'($urandom), ra,
           4'($urandom_range(0, 3)), 1'($urandom), 4'($urandom_range(0, 3)),
           1'($urandom_range(0, 3) != 0), $urandom);
    end
    step("R9", 0, 2'b00, 19'h0, 4'd0, 0, 4'd0, 1, 32'h0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule